// File: doc/BRIEF.md
# Glitch-Free Switchable Clock Divider Bank

This block drives a bank of clock outputs. Each output takes one of several source clocks and divides it by an integer. Every output holds two complete settings, each a source select and a divide value. One frequency-select input, shared by the bank, picks which of the two settings each output uses. Each output also has its own enable. A disabled output idles low.

The source clocks enter as levels sampled by a fast system clock `clk`. Each output is the registered state of a small state machine that advances on rising edges of its selected source. A new setting takes effect only where the output waveform is already low and a period is complete. This covers a change of the select input, a rewrite of the setting in use, and a change of enable. As a result, frequency changes never produce a runt pulse or a clipped high or low phase. A divide value below two passes the source waveform straight through, one `clk` cycle late.

Each output steps through five named states:
- `ST_IDLE`: disabled, output low.
- `ST_ARM`: enabled, output low, waiting for a rising edge of the selected source.
- `ST_HIGH`: counting the high phase.
- `ST_LOW`: counting the low phase.
- `ST_PASS`: divide-by-one pass-through.

The transitions are:
- Idle to arm when the enable rises.
- Arm to high, or arm to pass, on a rising edge of the source.
- High to low when the high count is reached.
- Low to high, low to pass, low to arm, or low to idle at the period boundary.
- Pass to arm, or pass to idle, once the output is low and a change is pending.
- Arm to idle when the enable falls.

Top module: `gdiv_bank`

## Requirements
- R1: With a divide value N of 2 or more, the output period is N periods of the selected source. The output is high for floor(N/2) source periods and low for the remaining ceil(N/2), so an odd N gives a high phase one source period shorter than the low phase. Every output edge follows a rising edge of the source.
- R2: A divide value of 0 or 1 makes the output follow the selected source level, delayed by one `clk` cycle.
- R3: Each output has two settings. While `fs_i` is 0 it uses setting 0 (`cfg0_sel_i`, `cfg0_div_i`). While `fs_i` is 1 it uses setting 1 (`cfg1_sel_i`, `cfg1_div_i`). Output k owns bits [k*SEL_W +: SEL_W] of each select bus and bits [k*DIV_W +: DIV_W] of each divide bus.
- R4: A select value s below NUM_SRC picks `src_i[s]`. A select value with no source behind it (6 or 7 with the default of six sources) keeps the output low.
- R5: A change of setting, through `fs_i` or through new values on the setting inputs, takes effect only at the end of a complete output period, after the low phase. The period in progress finishes with the old values.
- R6: After a switch to a different source, the output stays low until the next rising edge of the new source. The first high phase then has its full length, and no output phase is ever shorter than half a source period.
- R7: When the enable falls, a high phase in progress completes and the output then stays low. When the enable rises, the output stays low until a rising edge of the source and then emits a full-length high phase.
- R8: While `rst_n` is low, all outputs are low. After reset, an output with its enable low stays low.
- R9: Each output divides independently according to its own setting and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for sources and state |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Source clock levels, synchronous to clk |
| fs_i | input | 1 | Setting select: 0 picks setting 0, 1 picks setting 1 |
| en_i | input | NUM_OUT | Per-output enable |
| cfg0_sel_i | input | NUM_OUT*SEL_W | Setting 0 source select per output |
| cfg0_div_i | input | NUM_OUT*DIV_W | Setting 0 divide value per output |
| cfg1_sel_i | input | NUM_OUT*SEL_W | Setting 1 source select per output |
| cfg1_div_i | input | NUM_OUT*DIV_W | Setting 1 divide value per output |
| clk_o | output | NUM_OUT | Divided, gated output clocks, idle low |

## Verification
The bench sweeps every source against divide values 1 to 7, and alternates the select input so that each setting slot is used. It checks measured high and low run lengths against the expected floor/ceil split. An odd-ratio error or an off-by-one counter would show up as a wrong run length.

Mid-high-phase changes of divide value, of source and of enable target the boundary rule. A design that applied the change at once would clip the running high phase. A design that started on the new source without waiting for its edge would emit a short first pulse. Running monitors catch any one-cycle runt, an unselectable source that leaks pulses, and pass-through mode that keeps toggling after the enable falls.

// File: rtl/gdiv_pkg.sv
package gdiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_HIGH,
        ST_LOW,
        ST_PASS
    } gdiv_state_e;

endpackage

// File: rtl/gdiv_src_sampler.sv
module gdiv_src_sampler #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    output logic [NUM_SRC-1:0] src_prev_o
);

    // One-cycle history of every source level, shared by all lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prev_o <= '0;
        end else begin
            src_prev_o <= src_i;
        end
    end

endmodule

// File: rtl/gdiv_lane.sv
module gdiv_lane
    import gdiv_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int SEL_W   = 3,
    parameter int DIV_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl_i,
    input  logic [NUM_SRC-1:0] src_prev_i,
    input  logic               fs_i,
    input  logic               en_i,
    input  logic [SEL_W-1:0]   cfg0_sel_i,
    input  logic [DIV_W-1:0]   cfg0_div_i,
    input  logic [SEL_W-1:0]   cfg1_sel_i,
    input  logic [DIV_W-1:0]   cfg1_div_i,
    output logic               clk_o
);

    localparam int PADW = 1 << SEL_W;

    gdiv_state_e        state_q, state_n;
    logic [DIV_W-1:0]   cnt_q, cnt_n;
    logic [SEL_W-1:0]   act_sel_q, act_sel_n;
    logic [DIV_W-1:0]   act_div_q, act_div_n;
    logic               out_q;

    logic [PADW-1:0]    lvl_pad, prev_pad;
    logic               cur_lvl, cur_rise, cur_fall;
    logic [SEL_W-1:0]   pend_sel;
    logic [DIV_W-1:0]   pend_div;
    logic               pend_pass, act_pass, changed;
    logic [DIV_W-1:0]   hi_len, lo_len;

    // Unpopulated select codes read as a source stuck low
    assign lvl_pad  = PADW'(src_lvl_i);
    assign prev_pad = PADW'(src_prev_i);
    assign cur_lvl  = lvl_pad[act_sel_q];
    assign cur_rise = lvl_pad[act_sel_q] & ~prev_pad[act_sel_q];
    assign cur_fall = ~lvl_pad[act_sel_q] & prev_pad[act_sel_q];

    assign pend_sel  = fs_i ? cfg1_sel_i : cfg0_sel_i;
    assign pend_div  = fs_i ? cfg1_div_i : cfg0_div_i;
    assign pend_pass = (pend_div < DIV_W'(2));
    assign act_pass  = (act_div_q < DIV_W'(2));
    assign changed   = (pend_sel != act_sel_q) || (pend_div != act_div_q);

    // High phase gets the smaller half of an odd ratio
    assign hi_len = act_div_q >> 1;
    assign lo_len = act_div_q - hi_len;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            act_sel_q <= '0;
            act_div_q <= '0;
        end else begin
            state_q   <= state_n;
            cnt_q     <= cnt_n;
            act_sel_q <= act_sel_n;
            act_div_q <= act_div_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n   = state_q;
        cnt_n     = cnt_q;
        act_sel_n = act_sel_q;
        act_div_n = act_div_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i) begin
                    act_sel_n = pend_sel;
                    act_div_n = pend_div;
                    state_n   = ST_ARM;
                end
            end
            ST_ARM: begin
                if (!en_i) begin
                    state_n = ST_IDLE;
                end else if (changed) begin
                    // Output is low: the latch may follow freely
                    act_sel_n = pend_sel;
                    act_div_n = pend_div;
                end else if (cur_rise) begin
                    if (act_pass) begin
                        state_n = ST_PASS;
                    end else begin
                        state_n = ST_HIGH;
                        cnt_n   = DIV_W'(1);
                    end
                end
            end
            ST_HIGH: begin
                if (cur_rise) begin
                    if (cnt_q == hi_len) begin
                        state_n = ST_LOW;
                        cnt_n   = DIV_W'(1);
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (cur_rise) begin
                    if (cnt_q != lo_len) begin
                        cnt_n = cnt_q + 1'b1;
                    end else if (!en_i) begin
                        state_n = ST_IDLE;
                    end else begin
                        // Period boundary: the only point a new setting lands
                        act_sel_n = pend_sel;
                        act_div_n = pend_div;
                        if (pend_sel != act_sel_q) begin
                            state_n = ST_ARM;
                        end else if (pend_pass) begin
                            state_n = ST_PASS;
                        end else begin
                            state_n = ST_HIGH;
                            cnt_n   = DIV_W'(1);
                        end
                    end
                end
            end
            ST_PASS: begin
                // Leave only where the output is, or is about to be, low
                if ((!en_i || changed) && !(out_q && cur_lvl)) begin
                    if (!en_i) begin
                        state_n = ST_IDLE;
                    end else begin
                        act_sel_n = pend_sel;
                        act_div_n = pend_div;
                        state_n   = ST_ARM;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Output register: glitch-free by being a single flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= (state_n == ST_HIGH) || ((state_n == ST_PASS) && cur_lvl);
        end
    end

    assign clk_o = out_q;

endmodule

// File: rtl/gdiv_bank.sv
module gdiv_bank #(
    parameter int NUM_SRC = 6,
    parameter int NUM_OUT = 8,
    parameter int DIV_W   = 8,
    parameter int SEL_W   = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_i,
    input  logic                     fs_i,
    input  logic [NUM_OUT-1:0]       en_i,
    input  logic [NUM_OUT*SEL_W-1:0] cfg0_sel_i,
    input  logic [NUM_OUT*DIV_W-1:0] cfg0_div_i,
    input  logic [NUM_OUT*SEL_W-1:0] cfg1_sel_i,
    input  logic [NUM_OUT*DIV_W-1:0] cfg1_div_i,
    output logic [NUM_OUT-1:0]       clk_o
);

    logic [NUM_SRC-1:0] src_prev;

    gdiv_src_sampler #(
        .NUM_SRC (NUM_SRC)
    ) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .src_prev_o (src_prev)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
        gdiv_lane #(
            .NUM_SRC (NUM_SRC),
            .SEL_W   (SEL_W),
            .DIV_W   (DIV_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_lvl_i  (src_i),
            .src_prev_i (src_prev),
            .fs_i       (fs_i),
            .en_i       (en_i[k]),
            .cfg0_sel_i (cfg0_sel_i[k*SEL_W +: SEL_W]),
            .cfg0_div_i (cfg0_div_i[k*DIV_W +: DIV_W]),
            .cfg1_sel_i (cfg1_sel_i[k*SEL_W +: SEL_W]),
            .cfg1_div_i (cfg1_div_i[k*DIV_W +: DIV_W]),
            .clk_o      (clk_o[k])
        );
    end

endmodule

// File: rtl/gdiv_lane_chk.sv
module gdiv_lane_chk #(
    parameter int NUM_SRC = 6,
    parameter int SEL_W   = 3,
    parameter int DIV_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             clk_o,
    input logic             src_rise,
    input logic             src_fall,
    input logic [SEL_W-1:0] act_sel,
    input logic [DIV_W-1:0] act_div
);

    AST_OFF_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clk_o) |=> !clk_o);                                   // R7

    AST_RISE_AT_SOURCE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_o) |-> $past(src_rise));                               // R1

    AST_FALL_AT_SOURCE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_o) |-> $past(src_rise || src_fall));                   // R6

    AST_CFG_HELD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_o && $past(clk_o)) |-> ($stable(act_sel) && $stable(act_div))); // R5

    AST_NO_SOURCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(act_sel) >= NUM_SRC) |-> !clk_o);                          // R4

endmodule

bind gdiv_lane gdiv_lane_chk #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W),
    .DIV_W   (DIV_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .clk_o    (clk_o),
    .src_rise (cur_rise),
    .src_fall (cur_fall),
    .act_sel  (act_sel_q),
    .act_div  (act_div_q)
);

// File: tb/gdiv_bank_test.sv
`timescale 1ns/1ps
module gdiv_bank_test;

    localparam int NUM_SRC = 6;
    localparam int NUM_OUT = 8;
    localparam int DIV_W   = 8;
    localparam int SEL_W   = 3;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_SRC-1:0]       src = '0;
    logic                     fs = 1'b0;
    logic [NUM_OUT-1:0]       en = '0;
    logic [NUM_OUT*SEL_W-1:0] c0s = '0, c1s = '0;
    logic [NUM_OUT*DIV_W-1:0] c0d = '0, c1d = '0;
    logic [NUM_OUT-1:0]       clk_o;

    int checks = 0;
    int errors = 0;
    int runts  = 0;

    gdiv_bank #(
        .NUM_SRC (NUM_SRC),
        .NUM_OUT (NUM_OUT),
        .DIV_W   (DIV_W)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src),
        .fs_i       (fs),
        .en_i       (en),
        .cfg0_sel_i (c0s),
        .cfg0_div_i (c0d),
        .cfg1_sel_i (c1s),
        .cfg1_div_i (c1d),
        .clk_o      (clk_o)
    );

    always #2.5 clk = ~clk;

    // Source k: half period k+2 clk cycles, full period 2k+4
    int hc [NUM_SRC];
    initial for (int k = 0; k < NUM_SRC; k++) hc[k] = 0;
    always @(negedge clk) begin
        for (int k = 0; k < NUM_SRC; k++) begin
            if (hc[k] == k + 1) begin
                hc[k]  <= 0;
                src[k] <= ~src[k];
            end else begin
                hc[k] <= hc[k] + 1;
            end
        end
    end

    // Runt monitor on output 0 (R6): no phase shorter than two clk cycles
    logic mon_v = 1'b0;
    int   mon_n = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (clk_o[0] != mon_v) begin
                if (mon_n < 2) runts++;
                mon_v = clk_o[0];
                mon_n = 1;
            end else begin
                mon_n++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int lane, input bit slot, input int sel, input int dv);
        if (slot) begin
            c1s[lane*SEL_W +: SEL_W] = SEL_W'(sel);
            c1d[lane*DIV_W +: DIV_W] = DIV_W'(dv);
        end else begin
            c0s[lane*SEL_W +: SEL_W] = SEL_W'(sel);
            c0d[lane*DIV_W +: DIV_W] = DIV_W'(dv);
        end
    endtask

    task automatic wait_lvl(input int lane, input bit v);
        int n = 0;
        while (clk_o[lane] != v && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_len(input int lane, output int n);
        bit v = clk_o[lane];
        n = 0;
        while (clk_o[lane] == v && n < 3000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input int lane, output int hi, output int lo);
        wait_lvl(lane, 1'b0);
        wait_lvl(lane, 1'b1);
        run_len(lane, hi);
        run_len(lane, lo);
    endtask

    task automatic count_high(input int lane, input int cyc, output int n);
        n = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (clk_o[lane]) n++;
        end
    endtask

    initial begin
        int hi, lo, p, d, s, n, pre;
        // R8: outputs low in reset
        repeat (6) @(negedge clk);
        chk("R8 reset low", int'(clk_o), 0);
        rst_n = 1'b1;
        set_cfg(3, 1'b0, 1, 3);
        set_cfg(3, 1'b1, 1, 3);
        count_high(0, 40, n);
        chk("R8 disabled after reset", n, 0);

        en[0] = 1'b1;
        en[3] = 1'b1;

        // R1 R2 R3 R4 sweep: every source, ratios 1..7, both setting slots
        for (int i = 0; i < NUM_SRC * 7; i++) begin
            s = i / 7;
            d = (i % 7) + 1;
            p = 2 * s + 4;
            fs = i[0];
            set_cfg(0, i[0], s, d);
            set_cfg(0, ~i[0], 4, 3);      // unused slot holds other values (R3)
            measure(0, hi, lo);
            measure(0, hi, lo);
            if (d == 1) begin
                chk("R2 pass high", hi, p / 2);
                chk("R2 pass low", lo, p / 2);
            end else begin
                chk("R1 high phase", hi, (d / 2) * p);
                chk("R1 low phase", lo, (d - d / 2) * p);
            end
        end

        fs = 1'b0;
        // R4: select code without a source keeps output low
        set_cfg(0, 1'b0, 6, 3);
        repeat (120) @(negedge clk);
        count_high(0, 200, n);
        chk("R4 empty select low", n, 0);

        // R5: new ratio written during a high phase lands after the period
        set_cfg(0, 1'b0, 5, 6);
        measure(0, hi, lo);
        wait_lvl(0, 1'b0);
        wait_lvl(0, 1'b1);
        repeat (10) @(negedge clk);
        set_cfg(0, 1'b0, 5, 2);
        run_len(0, n);
        chk("R5 old high kept", n + 10, 42);
        run_len(0, lo);
        chk("R5 old low kept", lo, 42);
        run_len(0, hi);
        chk("R5 new high", hi, 14);
        run_len(0, lo);
        chk("R5 new low", lo, 14);

        // R6: source switch mid-high waits for the new source edge
        set_cfg(0, 1'b0, 5, 6);
        measure(0, hi, lo);
        wait_lvl(0, 1'b0);
        wait_lvl(0, 1'b1);
        repeat (10) @(negedge clk);
        set_cfg(0, 1'b0, 2, 2);
        run_len(0, n);
        chk("R6 old high kept", n + 10, 42);
        run_len(0, lo);
        chk("R6 low not clipped", int'(lo >= 42), 1);
        run_len(0, hi);
        chk("R6 first new high full", hi, 8);
        run_len(0, lo);
        chk("R6 new low", lo, 8);

        // R7: enable drop mid-high completes the pulse then stays low
        set_cfg(0, 1'b0, 5, 6);
        measure(0, hi, lo);
        wait_lvl(0, 1'b0);
        wait_lvl(0, 1'b1);
        repeat (10) @(negedge clk);
        en[0] = 1'b0;
        run_len(0, n);
        chk("R7 high completes", n + 10, 42);
        count_high(0, 300, n);
        chk("R7 off stays low", n, 0);
        en[0] = 1'b1;
        wait_lvl(0, 1'b1);
        run_len(0, hi);
        chk("R7 first high full", hi, 42);

        // R7: pass-through mode stops cleanly
        set_cfg(0, 1'b0, 0, 1);
        measure(0, hi, lo);
        measure(0, hi, lo);
        chk("R2 pass high", hi, 2);
        repeat (3) @(negedge clk);
        en[0] = 1'b0;
        repeat (6) @(negedge clk);
        count_high(0, 100, n);
        chk("R7 pass off low", n, 0);

        // R9: other output ran its own setting throughout
        measure(3, hi, lo);
        chk("R9 lane3 high", hi, 6);
        chk("R9 lane3 low", lo, 12);

        chk("R6 no runt pulses", runts, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule